// File: doc/BRIEF.md
# Branch Target Buffer

The block predicts where the instruction fetch should go next. The fetch stage presents its program counter, and in the same cycle the buffer answers with three things: whether it holds an entry for that exact address, whether the branch there is expected to be taken, and the address to fetch next. The buffer is direct-mapped. Each slot stores a valid bit, an address tag, a branch target and a 2-bit saturating direction counter. A slot is only trusted when its tag matches every upper bit of the fetch address. A slot that belongs to some other branch mapping to the same index therefore never redirects fetch.

After a branch executes, the pipeline reports the branch address, its actual direction and its actual target on the update port. A branch that already has a slot moves its counter one step toward the outcome. A taken branch replaces the stored target. A branch without a slot gets one only if it was taken. That new slot starts at weakly taken and overwrites whatever the slot held before. Reads are combinational from the stored state, and writes land on the clock edge. A lookup in the same cycle as an update therefore sees the contents from before the update.

Top module: `btb_predictor`

## Requirements
- R1: The lookup is combinational. In the cycle `fetch_pc` is applied, `pred_hit`, `pred_taken`, `pred_target` and `next_pc` reflect the stored state. On a miss, `pred_target` equals `fetch_pc + 4`.
- R2: `pred_hit` is 1 only when the slot selected by the index is valid and its stored tag equals `fetch_pc[PC_W-1:IDX_W+2]`. A different branch that maps to the same index gives a miss, not taken, and `next_pc = fetch_pc + 4`.
- R3: `next_pc` is the stored target when `pred_taken` is 1 and `fetch_pc + 4` otherwise. This holds for a hit whose counter predicts not taken as well.
- R4: The direction counter uses 2 bits: 0 strongly not taken, 1 weakly not taken, 2 weakly taken, 3 strongly taken. `pred_taken` is 1 on a hit whose counter is 2 or 3. On an update that hits, a taken branch raises the counter by one, saturating at 3, and a not-taken branch lowers it by one, saturating at 0.
- R5: A taken update that misses writes the slot with valid set, the update tag, the update target and counter 2.
- R6: A not-taken update that misses changes nothing. A branch already stored at that index still hits afterwards with its own prediction.
- R7: The index is `pc[IDX_W+1:2]` and the tag is `pc[PC_W-1:IDX_W+2]`. Bits 1:0 take no part in lookup or update.
- R8: When an update and a lookup select the same slot in the same cycle, the lookup returns the contents from before the update.
- R9: After reset every slot is invalid, so every lookup misses.
- R10: On an update that hits, a taken outcome replaces the stored target with `upd_target`. A not-taken outcome keeps the stored target.
- R11: The default table has 512 slots. Two addresses 2048 bytes apart share a slot, and a taken miss by one of them evicts the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched |
| pred_hit | output | 1 | Full-tag match on a valid slot |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_target | output | PC_W | Stored target on hit, fetch_pc+4 on miss |
| next_pc | output | PC_W | Chosen next fetch address |
| upd_valid | input | 1 | A resolved branch is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | PC_W | Resolved target address |

## Verification
The hardest case to reach is aliasing. Two branches must share an index but differ in tag. A non-allocating not-taken miss must leave the owner in place, and a taken miss must then evict it. The stimulus builds this on purpose with addresses 2048 bytes apart, and it interleaves lookups of both addresses between the updates. A separate sequence drives update and lookup to the same slot in one cycle to expose the old-contents read. A counter walk of repeated taken and then not-taken updates pushes the counter into both saturation limits. A final randomised phase over a small set of colliding addresses mixes all of these.

// File: rtl/btb_pkg.sv
package btb_pkg;

   localparam int unsigned INSTR_BYTES = 4;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } dir_ctr_e;

   function automatic dir_ctr_e ctr_step(input dir_ctr_e cur, input logic taken);
      dir_ctr_e res;
      res = cur;
      if (taken) begin
         if (cur != CTR_STRONG_T) res = dir_ctr_e'(cur + 2'd1);
      end else begin
         if (cur != CTR_STRONG_NT) res = dir_ctr_e'(cur - 2'd1);
      end
      return res;
   endfunction

   function automatic logic ctr_predicts_taken(input dir_ctr_e cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/btb_pc_split.sv
module btb_pc_split #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 9,
   parameter int unsigned TAG_W = PC_W - IDX_W - 2
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);

   initial begin
      if (TAG_W != PC_W - IDX_W - 2)
         $error("btb_pc_split: TAG_W must equal PC_W - IDX_W - 2");
   end

   assign idx = pc[IDX_W+1:2];
   assign tag = pc[PC_W-1:IDX_W+2];

endmodule

// File: rtl/btb_table.sv
module btb_table
   import btb_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned ENTRIES   = 512,
   parameter int unsigned IDX_W     = $clog2(ENTRIES),
   parameter int unsigned TAG_W     = PC_W - IDX_W - 2,
   parameter bit          RESET_ALL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   // fetch read port
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [PC_W-1:0]   rd_target,
   output dir_ctr_e          rd_ctr,
   // update read port
   input  logic [IDX_W-1:0]  up_idx,
   output logic              up_valid,
   output logic [TAG_W-1:0]  up_tag,
   output logic [PC_W-1:0]   up_target,
   output dir_ctr_e          up_ctr,
   // write port
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [PC_W-1:0]   wr_target,
   input  dir_ctr_e          wr_ctr
);

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [PC_W-1:0]    tgt_q [ENTRIES];
   dir_ctr_e           ctr_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else if (wr_en) valid_q[wr_idx] <= 1'b1;
   end

   generate
      if (RESET_ALL) begin : g_reset_fields
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < ENTRIES; i++) begin
                  tag_q[i] <= '0;
                  tgt_q[i] <= '0;
                  ctr_q[i] <= CTR_STRONG_NT;
               end
            end else if (wr_en) begin
               tag_q[wr_idx] <= wr_tag;
               tgt_q[wr_idx] <= wr_target;
               ctr_q[wr_idx] <= wr_ctr;
            end
         end
      end else begin : g_plain_fields
         always_ff @(posedge clk) begin
            if (wr_en) begin
               tag_q[wr_idx] <= wr_tag;
               tgt_q[wr_idx] <= wr_target;
               ctr_q[wr_idx] <= wr_ctr;
            end
         end
      end
   endgenerate

   assign rd_valid  = valid_q[rd_idx];
   assign rd_tag    = tag_q[rd_idx];
   assign rd_target = tgt_q[rd_idx];
   assign rd_ctr    = ctr_q[rd_idx];

   assign up_valid  = valid_q[up_idx];
   assign up_tag    = tag_q[up_idx];
   assign up_target = tgt_q[up_idx];
   assign up_ctr    = ctr_q[up_idx];

   // checker state: remember last write to confirm it landed
   logic             chk_vld_q;
   logic [IDX_W-1:0] chk_idx_q;
   logic [TAG_W-1:0] chk_tag_q;
   logic [PC_W-1:0]  chk_tgt_q;
   dir_ctr_e         chk_ctr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_vld_q <= 1'b0;
         chk_idx_q <= '0;
         chk_tag_q <= '0;
         chk_tgt_q <= '0;
         chk_ctr_q <= CTR_STRONG_NT;
      end else begin
         chk_vld_q <= wr_en;
         chk_idx_q <= wr_idx;
         chk_tag_q <= wr_tag;
         chk_tgt_q <= wr_target;
         chk_ctr_q <= wr_ctr;
      end
   end

   // R5: a write becomes a valid slot with the written fields one cycle later
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      chk_vld_q |-> (valid_q[chk_idx_q] && tag_q[chk_idx_q] == chk_tag_q
                     && tgt_q[chk_idx_q] == chk_tgt_q && ctr_q[chk_idx_q] == chk_ctr_q));

   // R9: nothing becomes valid without a write
   p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(valid_q));

endmodule

// File: rtl/btb_update_ctrl.sv
module btb_update_ctrl
   import btb_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 9,
   parameter int unsigned TAG_W = PC_W - IDX_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_valid,
   input  logic              upd_taken,
   input  logic [PC_W-1:0]   upd_target,
   input  logic [IDX_W-1:0]  upd_idx,
   input  logic [TAG_W-1:0]  upd_tag,
   input  logic              up_valid,
   input  logic [TAG_W-1:0]  up_tag,
   input  logic [PC_W-1:0]   up_target,
   input  dir_ctr_e          up_ctr,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [TAG_W-1:0]  wr_tag,
   output logic [PC_W-1:0]   wr_target,
   output dir_ctr_e          wr_ctr
);

   logic up_hit;

   assign up_hit = up_valid && (up_tag == upd_tag);

   always_comb begin
      wr_en     = upd_valid && (up_hit || upd_taken);
      wr_idx    = upd_idx;
      wr_tag    = upd_tag;
      wr_target = upd_target;
      wr_ctr    = CTR_WEAK_T;
      if (up_hit) begin
         wr_ctr = ctr_step(up_ctr, upd_taken);
         if (!upd_taken) wr_target = up_target;
      end
   end

   // R6: a not-taken miss never writes
   p_nt_miss_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && !upd_taken && !(up_valid && up_tag == upd_tag)) |-> !wr_en);

   // R5: allocation starts weakly taken
   p_alloc_weak_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(up_valid && up_tag == upd_tag)) |-> wr_ctr == CTR_WEAK_T);

   // R4: a hit update moves the counter by at most one step
   p_ctr_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && up_valid && up_tag == upd_tag) |->
         (wr_ctr == up_ctr || wr_ctr == dir_ctr_e'(up_ctr + 2'd1)
          || wr_ctr == dir_ctr_e'(up_ctr - 2'd1)));

   // R10: a not-taken hit keeps the stored target
   p_nt_keeps_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !upd_taken) |-> wr_target == up_target);

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
   import btb_pkg::*;
#(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned ENTRIES   = 512,
   parameter bit          RESET_ALL = 1'b0,
   localparam int unsigned IDX_W    = $clog2(ENTRIES),
   localparam int unsigned TAG_W    = PC_W - IDX_W - 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_target,
   output logic [PC_W-1:0] next_pc,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken,
   input  logic [PC_W-1:0] upd_target
);

   initial begin
      if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0)
         $error("btb_predictor: ENTRIES must be a power of two of at least 2");
      if (PC_W <= IDX_W + 2)
         $error("btb_predictor: PC_W too small for the index");
   end

   logic [IDX_W-1:0] f_idx, u_idx;
   logic [TAG_W-1:0] f_tag, u_tag;

   btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_split_fetch (
      .pc(fetch_pc), .idx(f_idx), .tag(f_tag));

   btb_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_split_upd (
      .pc(upd_pc), .idx(u_idx), .tag(u_tag));

   logic             rd_valid, up_valid, wr_en;
   logic [TAG_W-1:0] rd_tag, up_tag, wr_tag;
   logic [PC_W-1:0]  rd_target, up_target, wr_target;
   logic [IDX_W-1:0] wr_idx;
   dir_ctr_e         rd_ctr, up_ctr, wr_ctr;

   btb_table #(
      .PC_W(PC_W), .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
      .RESET_ALL(RESET_ALL)
   ) i_table (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag),
      .rd_target(rd_target), .rd_ctr(rd_ctr),
      .up_idx(u_idx), .up_valid(up_valid), .up_tag(up_tag),
      .up_target(up_target), .up_ctr(up_ctr),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
      .wr_target(wr_target), .wr_ctr(wr_ctr));

   btb_update_ctrl #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_upd (
      .clk(clk), .rst_n(rst_n),
      .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_target(upd_target),
      .upd_idx(u_idx), .upd_tag(u_tag),
      .up_valid(up_valid), .up_tag(up_tag), .up_target(up_target), .up_ctr(up_ctr),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
      .wr_target(wr_target), .wr_ctr(wr_ctr));

   logic [PC_W-1:0] seq_pc;

   assign seq_pc      = fetch_pc + PC_W'(INSTR_BYTES);
   assign pred_hit    = rd_valid && (rd_tag == f_tag);
   assign pred_taken  = pred_hit && ctr_predicts_taken(rd_ctr);
   assign pred_target = pred_hit ? rd_target : seq_pc;
   assign next_pc     = pred_taken ? pred_target : seq_pc;

   // R3: without a hit, fetch falls through sequentially
   p_miss_falls_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_hit |-> (next_pc == fetch_pc + PC_W'(INSTR_BYTES) && !pred_taken));

   // R8: with a steady fetch address, the prediction changes only after an update
   p_stable_without_update_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_valid && $stable(fetch_pc)) |=> (!$past(upd_valid) && $stable(fetch_pc))
         |-> ($stable(pred_hit) && $stable(next_pc)));

endmodule

// File: tb/test_btb_predictor.sv
module test_btb_predictor;

   localparam int CLK_PERIOD = 10;
   localparam int PC_W = 32;
   localparam int ENT  = 512;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc = '0;
   logic            pred_hit, pred_taken;
   logic [PC_W-1:0] pred_target, next_pc;
   logic            upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic            upd_taken = 1'b0;
   logic [PC_W-1:0] upd_target = '0;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   // reference model
   bit              m_valid [ENT];
   logic [PC_W-1:0] m_tag   [ENT];
   logic [PC_W-1:0] m_tgt   [ENT];
   int              m_ctr   [ENT];

   always #(CLK_PERIOD/2) clk = ~clk;

   btb_predictor i_btb_predictor (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_hit(pred_hit), .pred_taken(pred_taken),
      .pred_target(pred_target), .next_pc(next_pc),
      .upd_valid(upd_valid), .upd_pc(upd_pc),
      .upd_taken(upd_taken), .upd_target(upd_target));

   function automatic int idx_of(input logic [PC_W-1:0] pc);
      return int'((pc >> 2) % ENT);
   endfunction

   function automatic logic [PC_W-1:0] tag_of(input logic [PC_W-1:0] pc);
      return pc >> 11;
   endfunction

   task automatic step(input logic [PC_W-1:0] fpc, input bit uv,
                       input logic [PC_W-1:0] upc, input bit ut,
                       input logic [PC_W-1:0] utgt, input string req);
      int i;
      bit e_hit, e_tk;
      logic [PC_W-1:0] e_tgt, e_next;
      @(negedge clk);
      fetch_pc = fpc; upd_valid = uv; upd_pc = upc;
      upd_taken = ut; upd_target = utgt;
      #1;
      i = idx_of(fpc);
      e_hit  = m_valid[i] && m_tag[i] == tag_of(fpc);
      e_tk   = e_hit && m_ctr[i] >= 2;
      e_tgt  = e_hit ? m_tgt[i] : fpc + 4;
      e_next = e_tk ? m_tgt[i] : fpc + 4;
      n_checks++;
      if (pred_hit !== e_hit || pred_taken !== e_tk ||
          pred_target !== e_tgt || next_pc !== e_next) begin
         n_errors++;
         $display("FAIL %s pc=%h: hit/taken/target/next got %b %b %h %h expected %b %b %h %h",
                  req, fpc, pred_hit, pred_taken, pred_target, next_pc,
                  e_hit, e_tk, e_tgt, e_next);
      end
      @(posedge clk);
      if (uv) begin
         i = idx_of(upc);
         if (m_valid[i] && m_tag[i] == tag_of(upc)) begin
            if (ut) begin
               if (m_ctr[i] < 3) m_ctr[i]++;
               m_tgt[i] = utgt;
            end else if (m_ctr[i] > 0) m_ctr[i]--;
         end else if (ut) begin
            m_valid[i] = 1'b1; m_tag[i] = tag_of(upc);
            m_tgt[i] = utgt;   m_ctr[i] = 2;
         end
      end
   endtask

   task automatic look(input logic [PC_W-1:0] fpc, input string req);
      step(fpc, 1'b0, '0, 1'b0, '0, req);
   endtask

   initial begin
      for (int k = 0; k < ENT; k++) begin
         m_valid[k] = 1'b0; m_tag[k] = '0; m_tgt[k] = '0; m_ctr[k] = 0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R9: reset leaves every slot invalid
      look(32'h0000_1000, "R9");
      look(32'h0000_0000, "R9");
      look(32'hFFFF_FFFC, "R9");

      // R8: allocation and lookup of the same slot in one cycle
      step(32'h0000_1000, 1'b1, 32'h0000_1000, 1'b1, 32'h0000_2000, "R8");
      // R5 / R1 / R3: allocated slot is visible next cycle, taken
      look(32'h0000_1000, "R5");
      look(32'h0000_1000, "R1");
      // R7: low two bits ignored on lookup and on update
      look(32'h0000_1003, "R7");
      step(32'h0000_1000, 1'b1, 32'h0000_1002, 1'b1, 32'h0000_2000, "R7");
      look(32'h0000_1001, "R7");

      // R2 / R11: alias 2048 bytes above misses
      look(32'h0000_1800, "R2");
      // R6: not-taken miss leaves the owner in place
      step(32'h0000_1000, 1'b1, 32'h0000_1800, 1'b0, 32'h0000_4000, "R6");
      look(32'h0000_1000, "R6");
      look(32'h0000_1800, "R6");
      // R11: taken miss evicts the owner
      step(32'h0000_1800, 1'b1, 32'h0000_1800, 1'b1, 32'h0000_5000, "R11");
      look(32'h0000_1800, "R11");
      look(32'h0000_1000, "R11");

      // R4: counter walk to both limits
      step(32'h0000_3000, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_6000, "R4");
      for (int k = 0; k < 3; k++)
         step(32'h0000_3000, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_6000, "R4");
      for (int k = 0; k < 5; k++) begin
         step(32'h0000_3000, 1'b1, 32'h0000_3000, 1'b0, 32'h0000_6000, "R4");
         look(32'h0000_3000, "R3");
      end
      step(32'h0000_3000, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_6000, "R4");
      look(32'h0000_3000, "R3");
      step(32'h0000_3000, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_6000, "R4");
      look(32'h0000_3000, "R4");

      // R10: target replaced on taken hit, kept on not-taken hit
      step(32'h0000_3000, 1'b1, 32'h0000_3000, 1'b1, 32'h0000_7000, "R10");
      look(32'h0000_3000, "R10");
      step(32'h0000_3000, 1'b1, 32'h0000_3000, 1'b0, 32'h0000_9000, "R10");
      look(32'h0000_3000, "R10");

      // mixed phase over colliding addresses
      for (int k = 0; k < 400; k++) begin
         logic [PC_W-1:0] pcs [6];
         logic [PC_W-1:0] a, b;
         pcs = '{32'h0000_1000, 32'h0000_1800, 32'h0000_3000,
                 32'h0000_3800, 32'h0000_1004, 32'h1000_1000};
         a = pcs[$urandom % 6];
         b = pcs[$urandom % 6];
         step(a, ($urandom % 3) != 0, b, ($urandom % 2) == 1,
              32'h0000_8000 + 32'(($urandom % 16) * 4), "R8");
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: run did not complete, got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule